// File: doc/BRIEF.md
# March C- Self-Test Engine for a Single-Port SRAM

This block tests a single-port synchronous SRAM in place. While the self-test mode input is low, it passes the functional address, write data, write enable and chip select straight through to the memory. When self-test mode is raised, the block takes over those memory pins. It then runs the six-element March C- algorithm across a configurable window of word addresses. The algorithm repeats once for each word background. In each pass, a "0" in the algorithm stands for the background word and a "1" stands for its bitwise inverse.

Every read word is compared with the word the algorithm expects. Reads come back after a configurable latency, and the compare is delayed to match. A single fail bit records whether any mismatch was seen. An error map, one bit per data bit, accumulates the XOR of expected and returned data, so it shows which bit lanes failed. A done flag marks the end of the last compare. Dropping self-test mode stops the run at once and hands the memory port back to functional use.

Top module: `sram_march_bist`

## Requirements
- R1: While `test_mode` is 0, `mem_addr`, `mem_wdata`, `mem_we` and `mem_cs` equal `fn_addr`, `fn_wdata`, `fn_we` and `fn_cs` in the same cycle. While it is 1, the engine drives them.
- R2: Each background pass runs six elements in this order: write 0; (read 0, write 1); (read 1, write 0); (read 0, write 1); (read 1, write 0); read 0. A two-operation element does both operations on one address before it moves to the next address.
- R3: Every engine access lies in the range `LO_ADDR`..`HI_ADDR`. Elements 1 to 3 step the address upward from `LO_ADDR`. Elements 4 to 6 step it downward from `HI_ADDR`.
- R4: There are 1+clog2(`DATA_W`) backgrounds, used in index order. Background 0 is all zeros. In background k≥1, bit i is 1 exactly when bit k-1 of i is 0; for 4-bit data the backgrounds are 0000, 0101 and 0011. The algorithm's "1" is the bitwise inverse of the current background.
- R5: The engine issues one memory operation per cycle with `mem_cs`=1. The first operation appears in the first cycle that `test_mode` is 1. Each background takes exactly 10N cycles, where N = `HI_ADDR`-`LO_ADDR`+1.
- R6: The data for a read issued in cycle t is taken from `mem_rdata` in cycle t+`RD_LAT` and compared against that read's expected word.
- R7: `fail` becomes 1 on the first compare mismatch and stays 1 until reset. `err_map` is the OR, over all compares, of expected XOR returned data, and it is also held until reset.
- R8: `done` rises `RD_LAT`+1 cycles after the last read of the last background is issued. It stays 1, with `mem_cs`=0, for as long as `test_mode` remains 1.
- R9: One cycle after `test_mode` falls, `done` is 0. The next rise of `test_mode` restarts the algorithm from its first operation.
- R10: A synchronous active-low reset clears `done`, `fail` and `err_map`.
- R11: A fault at an address outside `LO_ADDR`..`HI_ADDR` never affects `fail` or `err_map`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory |
| rst_n | input | 1 | Synchronous reset, active low |
| test_mode | input | 1 | 1 hands the memory to the engine and runs the test |
| fn_addr | input | ADDR_W | Functional address |
| fn_wdata | input | DATA_W | Functional write data |
| fn_we | input | 1 | Functional write enable |
| fn_cs | input | 1 | Functional chip select |
| mem_rdata | input | DATA_W | Read data from the memory, RD_LAT cycles after the read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_cs | output | 1 | Memory chip select |
| done | output | 1 | Last compare finished; held while test_mode is 1 |
| fail | output | 1 | Sticky mismatch flag |
| err_map | output | DATA_W | Sticky per-bit mismatch map |

## Verification
The assertions assume the memory returns read data exactly `RD_LAT` cycles after each read, that `LO_ADDR` is no greater than `HI_ADDR`, and that reset is applied before the first run. The bench meets these conditions with a memory model that has a fixed one-cycle read latency. It changes `test_mode` and the functional inputs only on falling clock edges, and it injects stuck-at faults only on the read path. This leaves the write sequence the engine issues undisturbed, so the expected operation list can be computed directly from the algorithm.

// File: rtl/smb_pkg.sv
// Shared definitions for the March C- engine: element encoding and
// per-element decode helpers. Assumes elements run in encoding order.
package smb_pkg;

    typedef enum logic [2:0] {
        EL_W0_UP   = 3'd0,
        EL_R0W1_UP = 3'd1,
        EL_R1W0_UP = 3'd2,
        EL_R0W1_DN = 3'd3,
        EL_R1W0_DN = 3'd4,
        EL_R0_DN   = 3'd5
    } march_elem_e;

    // True when the element walks addresses from high to low.
    function automatic logic elem_desc(march_elem_e e);
        return (e == EL_R0W1_DN) || (e == EL_R1W0_DN) || (e == EL_R0_DN);
    endfunction

    // True when the element holds a read followed by a write.
    function automatic logic elem_two_op(march_elem_e e);
        return !((e == EL_W0_UP) || (e == EL_R0_DN));
    endfunction

    // Data polarity of an operation: 0 = background, 1 = inverse.
    function automatic logic op_pol(march_elem_e e, logic second);
        case (e)
            EL_R0W1_UP, EL_R0W1_DN: return second;
            EL_R1W0_UP, EL_R1W0_DN: return !second;
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/smb_seq.sv
// March C- sequencer: walks backgrounds, elements, addresses and
// operations, issuing one memory operation per cycle while run is high.
// Assumes LO_ADDR <= HI_ADDR. Dropping run resets the walk to its start.
module smb_seq
    import smb_pkg::*;
#(
    parameter int DATA_W  = 4,
    parameter int ADDR_W  = 3,
    parameter int LO_ADDR = 0,
    parameter int HI_ADDR = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic              b_cs,
    output logic              b_we,
    output logic [ADDR_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_wdata,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_exp,
    output logic              rd_last
);
    localparam int NBG  = 1 + $clog2(DATA_W);
    localparam int BG_W = (NBG > 1) ? $clog2(NBG) : 1;
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(HI_ADDR);
    localparam logic [BG_W-1:0] BG_LAST = BG_W'(NBG - 1);

    logic [DATA_W-1:0] bg_tbl [NBG];

    // Background words: index 0 is zero, index k>=1 sets bit i when bit k-1 of i is 0.
    for (genvar k = 0; k < NBG; k++) begin : g_bg
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            if (k == 0) begin : g_zero
                assign bg_tbl[k][i] = 1'b0;
            end else begin : g_stripe
                assign bg_tbl[k][i] = (((i >> (k - 1)) & 1) == 0);
            end
        end
    end

    march_elem_e       elem_q, elem_nx;
    logic [BG_W-1:0]   bg_q;
    logic [ADDR_W-1:0] addr_q;
    logic              op_q, fin_q;
    logic              active, two_op, desc, is_rd, pol, last_op, last_addr;
    logic [DATA_W-1:0] word;

    // Decode of the current operation.
    always_comb begin
        active    = run && !fin_q;
        two_op    = elem_two_op(elem_q);
        desc      = elem_desc(elem_q);
        is_rd     = (elem_q == EL_R0_DN) || (two_op && !op_q);
        pol       = op_pol(elem_q, op_q);
        last_op   = !two_op || op_q;
        last_addr = desc ? (addr_q == LO) : (addr_q == HI);
        elem_nx   = march_elem_e'(elem_q + 3'd1);
        word      = pol ? ~bg_tbl[bg_q] : bg_tbl[bg_q];
    end

    // Walk state advance: operation, then address, then element, then background.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            elem_q <= EL_W0_UP;
            bg_q   <= '0;
            addr_q <= LO;
            op_q   <= 1'b0;
            fin_q  <= 1'b0;
        end else if (active) begin
            if (!last_op) begin
                op_q <= 1'b1;
            end else begin
                op_q <= 1'b0;
                if (!last_addr) begin
                    addr_q <= desc ? addr_q - 1'b1 : addr_q + 1'b1;
                end else if (elem_q != EL_R0_DN) begin
                    elem_q <= elem_nx;
                    addr_q <= elem_desc(elem_nx) ? HI : LO;
                end else begin
                    elem_q <= EL_W0_UP;
                    addr_q <= LO;
                    if (bg_q == BG_LAST) fin_q <= 1'b1;
                    else                 bg_q  <= bg_q + 1'b1;
                end
            end
        end
    end

    // Operation outputs towards the port mux and the analyzer.
    always_comb begin
        b_cs    = active;
        b_we    = active && !is_rd;
        b_addr  = addr_q;
        b_wdata = word;
        rd_vld  = active && is_rd;
        rd_exp  = word;
        rd_last = (elem_q == EL_R0_DN) && last_addr && (bg_q == BG_LAST);
    end

endmodule

// File: rtl/smb_cmp.sv
// Read analyzer: delays each read's expected word by RD_LAT cycles,
// compares it with returned data, and keeps sticky fail/error-map state
// plus the done flag. Assumes read data arrives exactly RD_LAT cycles late.
module smb_cmp #(
    parameter int DATA_W = 4,
    parameter int RD_LAT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rd_vld,
    input  logic [DATA_W-1:0] rd_exp,
    input  logic              rd_last,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              fail,
    output logic [DATA_W-1:0] err_map
);
    logic              c_vld, c_last;
    logic [DATA_W-1:0] c_exp;

    if (RD_LAT == 0) begin : g_direct
        assign c_vld  = rd_vld;
        assign c_last = rd_last;
        assign c_exp  = rd_exp;
    end else begin : g_delay
        logic [RD_LAT-1:0] vld_sr, last_sr;
        logic [DATA_W-1:0] exp_sr [RD_LAT];

        // Control delay line, flushed when the run is abandoned.
        always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
                vld_sr  <= '0;
                last_sr <= '0;
            end else begin
                vld_sr[0]  <= rd_vld;
                last_sr[0] <= rd_last;
                for (int s = 1; s < RD_LAT; s++) begin
                    vld_sr[s]  <= vld_sr[s-1];
                    last_sr[s] <= last_sr[s-1];
                end
            end
        end

        // Expected-word delay line; data only, no reset needed.
        always_ff @(posedge clk) begin
            exp_sr[0] <= rd_exp;
            for (int s = 1; s < RD_LAT; s++) exp_sr[s] <= exp_sr[s-1];
        end

        assign c_vld  = vld_sr[RD_LAT-1];
        assign c_last = last_sr[RD_LAT-1];
        assign c_exp  = exp_sr[RD_LAT-1];
    end

    // Sticky result accumulation and end-of-test flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail    <= 1'b0;
            err_map <= '0;
            done    <= 1'b0;
        end else begin
            if (run && c_vld) begin
                err_map <= err_map | (c_exp ^ mem_rdata);
                if (c_exp != mem_rdata) fail <= 1'b1;
            end
            done <= run && (done || (c_vld && c_last));
        end
    end

endmodule

// File: rtl/sram_march_bist.sv
// SRAM self-test top: the port mux hands the memory to the March C-
// sequencer while test_mode is high; the analyzer checks read data.
// Assumes a single-port SRAM with fixed read latency RD_LAT.
module sram_march_bist #(
    parameter int DATA_W  = 4,
    parameter int ADDR_W  = 3,
    parameter int LO_ADDR = 0,
    parameter int HI_ADDR = (1 << ADDR_W) - 1,
    parameter int RD_LAT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic [ADDR_W-1:0] fn_addr,
    input  logic [DATA_W-1:0] fn_wdata,
    input  logic              fn_we,
    input  logic              fn_cs,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_cs,
    output logic              done,
    output logic              fail,
    output logic [DATA_W-1:0] err_map
);
    logic              b_cs, b_we, rd_vld, rd_last;
    logic [ADDR_W-1:0] b_addr;
    logic [DATA_W-1:0] b_wdata, rd_exp;

    smb_seq #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .run(test_mode),
        .b_cs(b_cs), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .rd_vld(rd_vld), .rd_exp(rd_exp), .rd_last(rd_last)
    );

    smb_cmp #(
        .DATA_W(DATA_W), .RD_LAT(RD_LAT)
    ) u_cmp (
        .clk(clk), .rst_n(rst_n), .run(test_mode),
        .rd_vld(rd_vld), .rd_exp(rd_exp), .rd_last(rd_last),
        .mem_rdata(mem_rdata),
        .done(done), .fail(fail), .err_map(err_map)
    );

    // Memory port ownership: functional logic or self-test engine.
    always_comb begin
        if (test_mode) begin
            mem_addr  = b_addr;
            mem_wdata = b_wdata;
            mem_we    = b_we;
            mem_cs    = b_cs;
        end else begin
            mem_addr  = fn_addr;
            mem_wdata = fn_wdata;
            mem_we    = fn_we;
            mem_cs    = fn_cs;
        end
    end

endmodule

// File: rtl/sram_march_bist_chk.sv
// Property checker for sram_march_bist, attached by bind. Observes ports
// only; assumes reset is applied before the first self-test run.
module sram_march_bist_chk #(
    parameter int DATA_W  = 4,
    parameter int ADDR_W  = 3,
    parameter int LO_ADDR = 0,
    parameter int HI_ADDR = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_mode,
    input logic [ADDR_W-1:0] fn_addr,
    input logic [DATA_W-1:0] fn_wdata,
    input logic              fn_we,
    input logic              fn_cs,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic              mem_cs,
    input logic              done,
    input logic              fail,
    input logic [DATA_W-1:0] err_map
);
    assert_mux_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |-> (mem_addr == fn_addr && mem_wdata == fn_wdata &&
                        mem_we == fn_we && mem_cs == fn_cs));

    assert_addr_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode && mem_cs) |-> (int'(mem_addr) >= LO_ADDR && int'(mem_addr) <= HI_ADDR));

    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> fail);

    assert_map_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_map & $past(err_map)) == $past(err_map)));

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && test_mode) |=> done);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && test_mode) |-> !mem_cs);

    assert_release_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !test_mode |=> !done);

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!done && !fail && err_map == '0));

endmodule

bind sram_march_bist sram_march_bist_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .fn_addr(fn_addr), .fn_wdata(fn_wdata), .fn_we(fn_we), .fn_cs(fn_cs),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_cs(mem_cs),
    .done(done), .fail(fail), .err_map(err_map)
);

// File: tb/sram_march_bist_tb.sv
// Bench: 4-bit x 8-word memory model, window 1..6, read latency 1.
// Replays the full March C- operation list per run and injects read-path
// stuck-at faults inside and outside the window.
module sram_march_bist_tb;
    localparam int DATA_W = 4;
    localparam int ADDR_W = 3;
    localparam int LO     = 1;
    localparam int HI     = 6;
    localparam int RD_LAT = 1;
    localparam int N      = HI - LO + 1;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic clk = 0;
    logic rst_n = 0;
    logic test_mode = 0;
    logic [ADDR_W-1:0] fn_addr = '0;
    logic [DATA_W-1:0] fn_wdata = '0;
    logic fn_we = 0, fn_cs = 0;
    logic [DATA_W-1:0] mem_rdata;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic mem_we, mem_cs, done, fail;
    logic [DATA_W-1:0] err_map;

    always #2 clk = ~clk;

    sram_march_bist #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LO_ADDR(LO), .HI_ADDR(HI), .RD_LAT(RD_LAT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .fn_addr(fn_addr), .fn_wdata(fn_wdata), .fn_we(fn_we), .fn_cs(fn_cs),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_cs(mem_cs),
        .done(done), .fail(fail), .err_map(err_map)
    );

    // Memory model with one-cycle read latency and a read-path stuck-at bit.
    logic [DATA_W-1:0] mem [1 << ADDR_W];
    logic [DATA_W-1:0] rd_q = '0;
    logic [DATA_W-1:0] rd_v;
    logic sa_en = 0;
    logic [ADDR_W-1:0] sa_addr = '0;
    int sa_bit = 0;
    logic sa_val = 0;

    initial for (int a = 0; a < (1 << ADDR_W); a++) mem[a] = '0;

    always @(posedge clk) begin
        if (mem_cs && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_cs && !mem_we) begin
            rd_v = mem[mem_addr];
            if (sa_en && mem_addr == sa_addr) rd_v[sa_bit] = sa_val;
            rd_q <= rd_v;
        end
    end
    assign mem_rdata = rd_q;

    logic [DATA_W-1:0] bgs [3] = '{4'b0000, 4'b0101, 4'b0011};

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1; #1;
        chk(!done && !fail && err_map == 0, "R10", "reset clears results",
            {done, fail, err_map}, 0);
    endtask

    // Full run: compare every issued operation with the algorithm, then done timing.
    task automatic run_march();
        int bad_we = 0, bad_addr = 0, bad_dat = 0, bad_cs = 0;
        int fa = -1, fe = -1;
        @(negedge clk); test_mode = 1; #1;
        for (int b = 0; b < 3; b++)
            for (int e = 0; e < 6; e++)
                for (int x = 0; x < N; x++) begin
                    int nops;
                    nops = (e == 0 || e == 5) ? 1 : 2;
                    for (int o = 0; o < nops; o++) begin
                        bit w, p;
                        int a;
                        logic [DATA_W-1:0] d;
                        a = (e >= 3) ? HI - x : LO + x;
                        case (e)
                            0:       begin w = 1; p = 0; end
                            1, 3:    begin w = (o == 1); p = (o == 1); end
                            2, 4:    begin w = (o == 1); p = (o == 0); end
                            default: begin w = 0; p = 0; end
                        endcase
                        d = p ? ~bgs[b] : bgs[b];
                        if (mem_cs !== 1'b1) bad_cs++;
                        if (mem_we !== w) bad_we++;
                        if (int'(mem_addr) != a) begin bad_addr++; if (fa < 0) begin fa = mem_addr; fe = a; end end
                        if (w && mem_wdata !== d) bad_dat++;
                        @(negedge clk); #1;
                    end
                end
        chk(bad_cs == 0, "R5", "cycles without an operation", bad_cs, 0);
        chk(bad_we == 0, "R2", "read/write order mismatches", bad_we, 0);
        chk(bad_addr == 0, "R3", "address mismatches (first shown)", fa, fe);
        chk(bad_dat == 0, "R4", "background data mismatches", bad_dat, 0);
        chk(!done && !mem_cs, "R8", "done low and port quiet right after last read",
            {done, mem_cs}, 0);
        @(negedge clk); #1;
        chk(done === 1'b1, "R8", "done RD_LAT+1 cycles after last read", done, 1);
        repeat (3) @(negedge clk); #1;
        chk(done === 1'b1 && !mem_cs, "R8", "done holds while test_mode high",
            {done, mem_cs}, 2);
    endtask

    task automatic release_mode(input bit exp_fail, input logic [DATA_W-1:0] exp_map);
        @(negedge clk);
        test_mode = 0;
        fn_addr = 3'd5; fn_wdata = 4'hA; fn_we = 1; fn_cs = 1; #1;
        chk(mem_addr == 3'd5 && mem_wdata == 4'hA && mem_we && mem_cs, "R1",
            "functional port restored", {mem_addr, mem_wdata, mem_we, mem_cs}, {3'd5, 4'hA, 2'b11});
        fn_we = 0; fn_cs = 0;
        @(negedge clk); #1;
        chk(!done, "R9", "done low after release", done, 0);
        chk(fail == exp_fail && err_map == exp_map, "R7", "results sticky after release",
            {fail, err_map}, {exp_fail, exp_map});
    endtask

    task automatic fault_run(input int a, input int bitn, input bit v,
                             input bit exp_fail, input string req);
        logic [DATA_W-1:0] em;
        em = exp_fail ? DATA_W'(1 << bitn) : '0;
        do_reset();
        sa_en = 1; sa_addr = ADDR_W'(a); sa_bit = bitn; sa_val = v;
        run_march();
        chk(fail == exp_fail, req, "fail flag for stuck bit", fail, exp_fail);
        chk(err_map == em, req, "error map for stuck bit", err_map, em);
        release_mode(exp_fail, em);
        sa_en = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; #1;
        chk(!done && !fail && err_map == 0, "R10", "state after reset",
            {done, fail, err_map}, 0);
        fn_addr = 3'd2; fn_wdata = 4'h6; fn_we = 1; fn_cs = 1; #1;
        chk(mem_addr == 3'd2 && mem_wdata == 4'h6 && mem_we && mem_cs, "R1",
            "pass-through while idle", {mem_addr, mem_wdata, mem_we, mem_cs}, {3'd2, 4'h6, 2'b11});
        fn_we = 0; fn_cs = 0;

        // Clean memory: latency-aligned compares must all match (R6).
        run_march();
        chk(!fail && err_map == 0, "R6", "clean run passes with delayed compare",
            {fail, err_map}, 0);
        release_mode(0, '0);

        fault_run(3, 2, 1, 1, "R7");
        fault_run(LO, 0, 0, 1, "R3");
        fault_run(HI, 3, 1, 1, "R3");
        fault_run(0, 1, 1, 0, "R11");
        fault_run(7, 2, 0, 0, "R11");

        // Abort mid-run, then the restart must replay from the first operation.
        do_reset();
        @(negedge clk); test_mode = 1;
        repeat (25) @(negedge clk);
        release_mode(0, '0);
        run_march();
        chk(!fail, "R9", "restarted run passes", fail, 0);
        release_mode(0, '0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R5 watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule